// File: doc/BRIEF.md
# Decoupled Register Access Bridge

This block connects a processor-side request port to a shared bus that a DMA-capable network controller also uses. The controller's control/status registers are reached indirectly. An address port selects a register index, and a data port then reaches the selected register. The bridge keeps one holding register that the processor sees. A read is answered at once from the holding register, and that read then starts a background fetch from the data port, which overwrites the holding register. A write is posted into the holding register and is forwarded to the controller as soon as the shared bus is granted. As a result the processor only waits when it issues a new access while the previous background transfer is still waiting on the bus.

After reset the bridge performs the address-port setup by itself. It requests the bus and writes the index `REG_INDEX` (default 0) to the address port exactly once. Every later transfer goes to the data port. The processor port is a valid/ready channel. `cpu_ready` low is a wait state. A request is accepted on a rising edge where `cpu_valid` and `cpu_ready` are both high. While the bridge stalls a request, the processor must keep `cpu_valid`, `cpu_we` and `cpu_wdata` stable.

The shared-bus side uses a request/grant handshake. `bus_port_sel` selects the port: 0 is the address port and 1 is the data port. `bus_wr_stb` marks a one-cycle write phase with `bus_ad_o` driven and `bus_ad_oe` high. `bus_rd_stb` marks a one-cycle read phase, and `bus_ad_i` is sampled at the end of that cycle.

Top module: `rab_bridge`

## Requirements
- R1: During reset `cpu_rdata` is 0 and `cpu_ready` is low. After reset `cpu_ready` stays low until the address-port setup write has completed, and `bus_req` is high in the first cycle after reset release.
- R2: The first shared-bus phase after reset is a write with `bus_port_sel`=0 that carries `REG_INDEX` on `bus_ad_o`. Every later phase has `bus_port_sel`=1.
- R3: An accepted read returns the current holding-register value on `cpu_rdata` in the cycle it is accepted. A single read therefore returns the value from before any refresh it triggers.
- R4: Each accepted read causes exactly one data-port read phase. The holding register takes `bus_ad_i` at the end of that phase, so a second read returns the controller's value as it was at that phase.
- R5: An accepted write sets `cpu_rdata` to the written data in the next cycle. It then causes exactly one data-port write phase that carries that data with `bus_ad_oe` high.
- R6: Each accepted access drives `cpu_ready` low from the next cycle until the cycle after its shared-bus phase. A request is not taken while `cpu_ready` is low.
- R7: `bus_req` stays high until `bus_gnt` arrives. A phase strobe occurs only while both `bus_req` and `bus_gnt` are high, and `bus_req` is low in the cycle after a strobe.
- R8: With an arbiter that grants the bridge as soon as a DMA tenure of at most T cycles ends, a posted write reaches its write phase within T+3 clock edges of its acceptance.
- R9: `bus_wr_stb` and `bus_rd_stb` are never high together, and `bus_ad_oe` is high only in write phases.
- R10: A request held off by `cpu_ready` low leaves `cpu_rdata` unchanged. The holding register changes only on an accepted write or at a data-port read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted when high with valid; low is a wait state |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Holding-register value (read data) |
| bus_req | output | 1 | Shared-bus request |
| bus_gnt | input | 1 | Shared-bus grant |
| bus_port_sel | output | 1 | 0 = address port, 1 = data port |
| bus_wr_stb | output | 1 | One-cycle write phase |
| bus_rd_stb | output | 1 | One-cycle read phase |
| bus_ad_oe | output | 1 | Bridge drives the shared address/data lines |
| bus_ad_o | output | DW | Value driven on the shared lines |
| bus_ad_i | input | DW | Value read from the shared lines |

## Verification
The bench models the controller register and an arbiter that hands out random DMA tenures, during which the register content also changes at random.

It targets three main corner cases:
- **Stale-then-fresh read.** The register value is changed between two reads. A design that refreshed before answering would return the new value on the first read. A design that never refreshed would return the old value on the second read.
- **Back-to-back access during a DMA tenure.** A second access issued while the first is still waiting for the bus must see wait states. A design that missed the stall would lose the write or overwrite the holding register while a transfer is pending.
- **Completion latency and setup write.** Posted writes are timed against the maximum tenure. The first bus phase is checked to be the address-port write, so a design that skipped setup or reissued it would be flagged.

// File: rtl/rab_pkg.sv
package rab_pkg;

  // Sequencer states: setup of the address port, then data-port transfers
  typedef enum logic [2:0] {
    SQ_SETUP_REQ,
    SQ_SETUP_PH,
    SQ_IDLE,
    SQ_REQ,
    SQ_PH
  } sq_state_t;

  // Control lines the sequencer drives towards the shared bus
  typedef struct packed {
    logic req;
    logic sel;
    logic wr;
    logic rd;
    logic oe;
  } bus_ctl_t;

endpackage

// File: rtl/rab_cpu_port.sv
module rab_cpu_port (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_valid,
  input  logic cpu_we,
  input  logic setup_done,
  input  logic xfer_done,
  output logic cpu_ready,
  output logic launch,
  output logic launch_we
);

  logic busy_q;

  // Wait state whenever a transfer is outstanding or setup is unfinished
  assign cpu_ready = setup_done && !busy_q;
  assign launch    = cpu_valid && cpu_ready;
  assign launch_we = cpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else if (launch) begin
      busy_q <= 1'b1;
    end else if (xfer_done) begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rab_hold_reg.sv
module rab_hold_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_wr,
  input  logic [DW-1:0] wr_val,
  input  logic          load_rd,
  input  logic [DW-1:0] rd_val,
  output logic [DW-1:0] hold
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else if (load_wr) begin
      hold <= wr_val;
    end else if (load_rd) begin
      hold <= rd_val;
    end
  end

endmodule

// File: rtl/rab_bus_seq.sv
module rab_bus_seq
  import rab_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned REG_INDEX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_gnt,
  output bus_ctl_t      ctl,
  output logic [DW-1:0] ad_o,
  output logic          setup_done,
  output logic          xfer_done,
  output logic          capture
);

  localparam logic [DW-1:0] IDX_VAL = DW'(REG_INDEX);

  sq_state_t state_q, state_d;
  logic      op_we_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_SETUP_REQ;
      op_we_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        op_we_q <= start_we;
      end
    end
  end

  always_comb begin
    state_d   = state_q;
    ctl       = '0;
    ad_o      = '0;
    xfer_done = 1'b0;
    capture   = 1'b0;
    unique case (state_q)
      SQ_SETUP_REQ: begin
        ctl.req = 1'b1;
        if (bus_gnt) state_d = SQ_SETUP_PH;
      end
      SQ_SETUP_PH: begin
        ctl.req = 1'b1;
        ctl.wr  = 1'b1;
        ctl.oe  = 1'b1;
        ad_o    = IDX_VAL;
        state_d = SQ_IDLE;
      end
      SQ_IDLE: begin
        if (start) state_d = SQ_REQ;
      end
      SQ_REQ: begin
        ctl.req = 1'b1;
        if (bus_gnt) state_d = SQ_PH;
      end
      SQ_PH: begin
        ctl.req   = 1'b1;
        ctl.sel   = 1'b1;
        ctl.wr    = op_we_q;
        ctl.rd    = !op_we_q;
        ctl.oe    = op_we_q;
        ad_o      = op_we_q ? wr_data : '0;
        xfer_done = 1'b1;
        capture   = !op_we_q;
        state_d   = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign setup_done = (state_q != SQ_SETUP_REQ) && (state_q != SQ_SETUP_PH);

endmodule

// File: rtl/rab_bridge.sv
module rab_bridge
  import rab_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned REG_INDEX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic          cpu_we,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_port_sel,
  output logic          bus_wr_stb,
  output logic          bus_rd_stb,
  output logic          bus_ad_oe,
  output logic [DW-1:0] bus_ad_o,
  input  logic [DW-1:0] bus_ad_i
);

  logic     setup_done, xfer_done, capture;
  logic     launch, launch_we;
  logic     [DW-1:0] hold;
  bus_ctl_t ctl;

  rab_cpu_port u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_we     (cpu_we),
    .setup_done (setup_done),
    .xfer_done  (xfer_done),
    .cpu_ready  (cpu_ready),
    .launch     (launch),
    .launch_we  (launch_we)
  );

  // Posted write data lives in the holding register; it cannot change
  // while a transfer is pending because the port is stalled.
  rab_hold_reg #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_wr (launch && launch_we),
    .wr_val  (cpu_wdata),
    .load_rd (capture),
    .rd_val  (bus_ad_i),
    .hold    (hold)
  );

  rab_bus_seq #(.DW(DW), .REG_INDEX(REG_INDEX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (launch),
    .start_we   (launch_we),
    .wr_data    (hold),
    .bus_gnt    (bus_gnt),
    .ctl        (ctl),
    .ad_o       (bus_ad_o),
    .setup_done (setup_done),
    .xfer_done  (xfer_done),
    .capture    (capture)
  );

  assign cpu_rdata    = hold;
  assign bus_req      = ctl.req;
  assign bus_port_sel = ctl.sel;
  assign bus_wr_stb   = ctl.wr;
  assign bus_rd_stb   = ctl.rd;
  assign bus_ad_oe    = ctl.oe;

endmodule

// File: rtl/rab_bridge_chk.sv
module rab_bridge_chk #(
  parameter int unsigned DW        = 16,
  parameter int unsigned REG_INDEX = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_valid,
  input logic          cpu_ready,
  input logic          cpu_we,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_port_sel,
  input logic          bus_wr_stb,
  input logic          bus_rd_stb,
  input logic          bus_ad_oe,
  input logic [DW-1:0] bus_ad_o,
  input logic [DW-1:0] bus_ad_i
);

  logic strobe, acc, setup_seen;
  assign strobe = bus_wr_stb || bus_rd_stb;
  assign acc    = cpu_valid && cpu_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) setup_seen <= 1'b0;
    else if (strobe) setup_seen <= 1'b1;
  end

  p_no_ready_before_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_seen |-> !cpu_ready);

  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !setup_seen) |-> (bus_wr_stb && !bus_port_sel && bus_ad_o == DW'(REG_INDEX)));

  p_data_port_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && setup_seen) |-> bus_port_sel);

  p_rd_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_stb |=> (cpu_rdata == $past(bus_ad_i)));

  p_wr_loads_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cpu_we) |=> (cpu_rdata == $past(cpu_wdata)));

  p_stall_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !cpu_ready);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  p_strobe_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (bus_req && bus_gnt));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !bus_req);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_wr_stb, bus_rd_stb}));

  p_oe_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> bus_wr_stb);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && cpu_we) && !bus_rd_stb) |=> $stable(cpu_rdata));

endmodule

bind rab_bridge rab_bridge_chk #(.DW(DW), .REG_INDEX(REG_INDEX)) chk_i (.*);

// File: tb/rab_bridge_tb_top.sv
module rab_bridge_tb_top;

  localparam int DW      = 16;
  localparam int MAX_DMA = 40;
  localparam int LAT_LIM = MAX_DMA + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_port_sel, bus_wr_stb, bus_rd_stb, bus_ad_oe;
  logic [DW-1:0] bus_ad_o;
  logic          gnt;
  logic [DW-1:0] ctrl_reg0;

  always #5 clk = ~clk;

  rab_bridge #(.DW(DW), .REG_INDEX(0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(gnt), .bus_port_sel(bus_port_sel),
    .bus_wr_stb(bus_wr_stb), .bus_rd_stb(bus_rd_stb), .bus_ad_oe(bus_ad_oe),
    .bus_ad_o(bus_ad_o), .bus_ad_i(ctrl_reg0)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, dma_left = 0;
  bit dma_en = 0, mut_en = 0, poke = 0, done = 0;
  logic [DW-1:0] poke_val = '0;

  // expected model state
  logic [DW-1:0] exp_hold = '0, pend_data = '0, cap_val = '0;
  bit cap_flag = 0, seen_setup = 0, prev_strobe = 0;
  int pend_kind = 0;   // 0 none, 1 read, 2 write
  int acc_cyc = 0, stall_cnt = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // arbiter and controller register model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      gnt <= 1'b0; dma_left <= 0; ctrl_reg0 <= '0;
    end else begin
      if (poke) ctrl_reg0 <= poke_val;
      else if (bus_wr_stb && bus_port_sel) ctrl_reg0 <= bus_ad_o;
      else if (dma_left > 0 && mut_en) ctrl_reg0 <= DW'($urandom);
      if (dma_left > 0) begin dma_left <= dma_left - 1; gnt <= 1'b0; end
      else if (gnt) gnt <= bus_req;
      else if (bus_req) gnt <= 1'b1;
      else if (dma_en && ($urandom % 4 == 0)) dma_left <= 1 + int'($urandom % MAX_DMA);
    end
  end

  // apply refresh capture to the model at the edge where the design takes it
  always @(posedge clk) begin
    if (cap_flag) begin exp_hold = cap_val; cap_flag = 0; end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_strobe) chk(!bus_req, "R7", "req released after phase", 32'(bus_req), 0);
      prev_strobe = bus_wr_stb || bus_rd_stb;
      chk(!(bus_wr_stb && bus_rd_stb) && (!bus_ad_oe || bus_wr_stb), "R9",
          "strobe/oe exclusivity", {bus_wr_stb, bus_rd_stb, bus_ad_oe}, 0);
      if (bus_wr_stb || bus_rd_stb) begin
        chk(gnt, "R7", "strobe without grant", 32'(gnt), 1);
        if (!seen_setup) begin
          chk(bus_wr_stb && !bus_port_sel && bus_ad_o == 0, "R2", "setup phase",
              {bus_wr_stb, bus_port_sel, bus_ad_o}, 32'h2_0000);
          seen_setup = 1;
        end else begin
          chk(bus_port_sel, "R2", "data port select", 32'(bus_port_sel), 1);
          if (bus_rd_stb) begin
            chk(pend_kind == 1, "R4", "read phase kind", pend_kind, 1);
            cap_val = ctrl_reg0; cap_flag = 1;
          end else begin
            chk(pend_kind == 2 && bus_ad_o == pend_data && bus_ad_oe, "R5",
                "posted write phase", bus_ad_o, pend_data);
            chk(cyc - acc_cyc <= LAT_LIM, "R8", "write latency", cyc - acc_cyc, LAT_LIM);
          end
          pend_kind = 0;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [DW-1:0] d, output logic [DW-1:0] got);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_wdata = d;
    while (!cpu_ready) begin
      stall_cnt++;
      chk(cpu_rdata == exp_hold, "R10", "hold during stall", cpu_rdata, exp_hold);
      @(negedge clk);
    end
    got = cpu_rdata;
    if (!we) begin
      chk(got == exp_hold, "R3", "immediate read value", got, exp_hold);
      pend_kind = 1;
    end else begin
      pend_kind = 2; pend_data = d; acc_cyc = cyc;
    end
    @(negedge clk);
    cpu_valid = 1'b0;
    chk(!cpu_ready, "R6", "ready low after accept", 32'(cpu_ready), 0);
    if (we) begin
      chk(cpu_rdata == d, "R5", "write updates hold", cpu_rdata, d);
      exp_hold = d;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    logic [DW-1:0] got;
    int s0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cpu_rdata == 0, "R1", "rdata in reset", cpu_rdata, 0);
    chk(!cpu_ready, "R1", "ready in reset", 32'(cpu_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready, "R1", "ready before setup", 32'(cpu_ready), 0);
    chk(bus_req, "R1", "setup request", 32'(bus_req), 1);
    wait_idle();
    chk(seen_setup, "R2", "setup done before ready", 32'(seen_setup), 1);
    chk(cpu_rdata == 0, "R1", "hold zero before refresh", cpu_rdata, 0);

    // directed: stale-then-fresh read
    access(1'b1, 16'h1234, got);
    wait_idle();
    chk(ctrl_reg0 == 16'h1234, "R5", "controller register written", ctrl_reg0, 16'h1234);
    @(negedge clk); poke_val = 16'hBEEF; poke = 1;
    @(negedge clk); poke = 0;
    access(1'b0, '0, got);
    chk(got == 16'h1234, "R3", "first read is stale", got, 16'h1234);
    access(1'b0, '0, got);
    chk(got == 16'hBEEF, "R4", "second read is fresh", got, 16'hBEEF);
    wait_idle();

    // directed: back-to-back during DMA
    dma_en = 1;
    s0 = stall_cnt;
    access(1'b1, 16'h00A5, got);
    access(1'b0, '0, got);
    chk(stall_cnt > s0, "R6", "back-to-back stalls", stall_cnt - s0, 1);
    chk(got == 16'h00A5, "R5", "read after posted write", got, 16'h00A5);

    // random mix
    mut_en = 1;
    for (int i = 0; i < 300; i++) begin
      access(1'($urandom % 2), DW'($urandom), got);
      if ($urandom % 3 == 0) repeat (1 + $urandom % 5) @(negedge clk);
    end
    wait_idle();
    done = 1;
    report();
  end

endmodule